// File: doc/BRIEF.md
# TFT Horizontal Line Timing Generator

This block produces the timing of one horizontal line for a TFT panel whose source drivers and gate drivers take separate control pulses. A free-running pixel counter sweeps each line. From its position the block places the line pulse and a one-clock source-driver start pulse, then the data-enable window. It also places an output-enable pulse and a gate-clock pulse for the gate drivers, and two level outputs that each invert once per line. Every edge is set by a programmable field and is counted in pixel clocks.

The fields are sampled into a shadow copy only when the counter returns to zero. A field written partway through a line therefore takes effect from the next line on. The block also flags a programmed line whose blanking after the display window is too short for the source-driver chain. The flag is computed from the fields of the line in progress.

Top module: `tft_hline_gen`

## Requirements
- R1: While reset is asserted, every output is low. The first line starts (count 0) on the first clock edge after reset is released. Both toggle outputs leave reset at 0.
- R2: A line lasts (cfg_total_i + 1) × 8 clocks, with the count running 0 up to that length − 1. line_o is high for counts 0 to cfg_lpw_i, which is cfg_lpw_i + 1 clocks.
- R3: The start delay is the 10-bit value {cfg_spd_hi_i, cfg_spd_lo_i}. stp_o is high for exactly one clock, at count start delay + 3.
- R4: de_o is high from count start delay + 4 for cfg_disp_i × 8 clocks. It stays low in a line whose cfg_disp_i is 0.
- R5: oe_o rises at count 2 × cfg_oe_dly_i and lasts 2 × cfg_oe_wid_i clocks. When cfg_oe_wid_i is 0, it lasts cfg_lpw_i + 1 clocks.
- R6: gck_o rises at count 0, together with line_o, and lasts 2 × cfg_gck_wid_i clocks. When cfg_gck_wid_i is 0, it lasts cfg_lpw_i + 1 clocks.
- R7: tga_o inverts at count 2 × cfg_tga_i of every line, and tgb_o inverts at count 2 × cfg_tgb_i. If that count lies beyond the end of the line, the output holds its level for that line.
- R8: cfg_err_o is high exactly when line length ≤ (start delay + 4) + cfg_disp_i × 8 + 3 × NUM_SRC_IC + 3, using the fields of the current line.
- R9: The fields are captured only at count 0. A change made during a line alters nothing until the next count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_total_i | input | 7 | Line length field, length = (value + 1) × 8 |
| cfg_lpw_i | input | 7 | Line pulse width − 1 |
| cfg_spd_hi_i | input | 2 | Upper two bits of the start delay |
| cfg_spd_lo_i | input | 8 | Lower eight bits of the start delay |
| cfg_disp_i | input | 7 | Display window length / 8 |
| cfg_oe_dly_i | input | 8 | Output-enable offset / 2 |
| cfg_oe_wid_i | input | 8 | Output-enable width / 2, 0 selects line pulse width |
| cfg_gck_wid_i | input | 8 | Gate-clock width / 2, 0 selects line pulse width |
| cfg_tga_i | input | 8 | Toggle A position / 2 |
| cfg_tgb_i | input | 8 | Toggle B position / 2 |
| line_o | output | 1 | Line pulse |
| stp_o | output | 1 | Source-driver start pulse |
| de_o | output | 1 | Data-enable window |
| oe_o | output | 1 | Gate output-enable pulse |
| gck_o | output | 1 | Gate-clock pulse |
| tga_o | output | 1 | Per-line toggle A |
| tgb_o | output | 1 | Per-line toggle B |
| cfg_err_o | output | 1 | Blanking rule violated for the current line |

## Verification
The bench drives the shortest line of eight clocks. A counter that is off by one at the wrap would show up there as a line of seven or nine clocks. Zero width fields are driven for both gate pulses, where a design that took the zero literally would emit no pulse at all. The blanking rule is hit exactly at its boundary and one count inside it, which catches a flag that compares with the wrong strictness. Fields are changed in the middle of a line, where a design without a shadow copy would stretch or cut the current line. Toggle positions are placed past the end of the line, where a design that wrapped the compare would invert the output anyway.

// File: rtl/tft_hline_pkg.sv
package tft_hline_pkg;

    localparam int TOT_W = 7;
    localparam int LPW_W = 7;
    localparam int SPH_W = 2;
    localparam int SPL_W = 8;
    localparam int SPD_W = SPH_W + SPL_W;
    localparam int DSP_W = 7;
    localparam int AUX_W = 8;
    localparam int POS_W = 13;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic [TOT_W-1:0] tot;
        logic [LPW_W-1:0] lpw;
        logic [SPD_W-1:0] spd;
        logic [DSP_W-1:0] dsp;
        logic [AUX_W-1:0] oed;
        logic [AUX_W-1:0] oew;
        logic [AUX_W-1:0] gcw;
        logic [AUX_W-1:0] tga;
        logic [AUX_W-1:0] tgb;
    } hfield_t;

    // line length in pixel clocks
    function automatic pos_t line_len(input logic [TOT_W-1:0] t);
        return (pos_t'(t) + pos_t'(1)) << 3;
    endfunction

    function automatic pos_t dbl(input logic [AUX_W-1:0] v);
        return pos_t'(v) << 1;
    endfunction

    // auxiliary width: zero falls back to the line pulse width
    function automatic pos_t aux_len(input logic [AUX_W-1:0] v,
                                     input logic [LPW_W-1:0] lpw);
        return (v == '0) ? (pos_t'(lpw) + pos_t'(1)) : dbl(v);
    endfunction

endpackage

// File: rtl/tft_hline_ctr.sv
module tft_hline_ctr
    import tft_hline_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  hfield_t fld_i,
    output logic    run_o,
    output pos_t    cnt_o,
    output pos_t    cnt_nxt_o,
    output hfield_t sh_o,
    output hfield_t sh_nxt_o
);

    typedef struct packed {
        logic    run;
        pos_t    cnt;
        hfield_t sh;
    } ctr_t;

    ctr_t st_d, st_q;
    pos_t last;

    always_comb begin
        st_d = st_q;
        last = line_len(st_q.sh.tot) - pos_t'(1);
        if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.cnt == last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + pos_t'(1);
        end
        // shadow copy refreshed only at the line start
        if (st_d.cnt == '0) begin
            st_d.sh = fld_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o     = st_q.run;
    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign sh_o      = st_q.sh;
    assign sh_nxt_o  = st_d.sh;

endmodule

// File: rtl/tft_hline_win.sv
module tft_hline_win
    import tft_hline_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pos_t pos_i,
    input  pos_t beg_i,
    input  pos_t len_i,
    output logic win_o
);

    typedef struct packed {
        logic win;
    } win_t;

    win_t w_d, w_q;
    pos_t stop;

    always_comb begin
        stop    = beg_i + len_i;
        w_d.win = (pos_i >= beg_i) && (pos_i < stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign win_o = w_q.win;

endmodule

// File: rtl/tft_hline_tgl.sv
module tft_hline_tgl
    import tft_hline_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pos_t pos_i,
    input  pos_t at_i,
    output logic lvl_o
);

    typedef struct packed {
        logic lvl;
    } tgl_t;

    tgl_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.lvl = t_q.lvl ^ (pos_i == at_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign lvl_o = t_q.lvl;

endmodule

// File: rtl/tft_hline_gen.sv
module tft_hline_gen
    import tft_hline_pkg::*;
#(
    parameter int NUM_SRC_IC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] cfg_total_i,
    input  logic [LPW_W-1:0] cfg_lpw_i,
    input  logic [SPH_W-1:0] cfg_spd_hi_i,
    input  logic [SPL_W-1:0] cfg_spd_lo_i,
    input  logic [DSP_W-1:0] cfg_disp_i,
    input  logic [AUX_W-1:0] cfg_oe_dly_i,
    input  logic [AUX_W-1:0] cfg_oe_wid_i,
    input  logic [AUX_W-1:0] cfg_gck_wid_i,
    input  logic [AUX_W-1:0] cfg_tga_i,
    input  logic [AUX_W-1:0] cfg_tgb_i,
    output logic             line_o,
    output logic             stp_o,
    output logic             de_o,
    output logic             oe_o,
    output logic             gck_o,
    output logic             tga_o,
    output logic             tgb_o,
    output logic             cfg_err_o
);

    localparam int   NWIN  = 5;
    localparam int   NTGL  = 2;
    localparam int   W_LN  = 0;
    localparam int   W_SP  = 1;
    localparam int   W_DE  = 2;
    localparam int   W_OE  = 3;
    localparam int   W_GC  = 4;
    localparam pos_t GUARD = pos_t'(NUM_SRC_IC * 3 + 3);

    hfield_t fld;
    hfield_t sh_q, sh_nxt;
    pos_t    cnt_q, cnt_nxt;
    logic    run_q;

    always_comb begin
        fld.tot = cfg_total_i;
        fld.lpw = cfg_lpw_i;
        fld.spd = {cfg_spd_hi_i, cfg_spd_lo_i};
        fld.dsp = cfg_disp_i;
        fld.oed = cfg_oe_dly_i;
        fld.oew = cfg_oe_wid_i;
        fld.gcw = cfg_gck_wid_i;
        fld.tga = cfg_tga_i;
        fld.tgb = cfg_tgb_i;
    end

    tft_hline_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_i     (fld),
        .run_o     (run_q),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt),
        .sh_o      (sh_q),
        .sh_nxt_o  (sh_nxt)
    );

    // window placement for the next count
    pos_t win_beg [NWIN];
    pos_t win_len [NWIN];
    pos_t data_beg;

    always_comb begin
        data_beg      = pos_t'(sh_nxt.spd) + pos_t'(4);
        win_beg[W_LN] = '0;
        win_len[W_LN] = pos_t'(sh_nxt.lpw) + pos_t'(1);
        win_beg[W_SP] = pos_t'(sh_nxt.spd) + pos_t'(3);
        win_len[W_SP] = pos_t'(1);
        win_beg[W_DE] = data_beg;
        win_len[W_DE] = pos_t'(sh_nxt.dsp) << 3;
        win_beg[W_OE] = dbl(sh_nxt.oed);
        win_len[W_OE] = aux_len(sh_nxt.oew, sh_nxt.lpw);
        win_beg[W_GC] = '0;
        win_len[W_GC] = aux_len(sh_nxt.gcw, sh_nxt.lpw);
    end

    logic [NWIN-1:0] win_q;

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            tft_hline_win u_win (
                .clk   (clk),
                .rst_n (rst_n),
                .pos_i (cnt_nxt),
                .beg_i (win_beg[g]),
                .len_i (win_len[g]),
                .win_o (win_q[g])
            );
        end
    endgenerate

    pos_t            tgl_at [NTGL];
    logic [NTGL-1:0] tgl_q;

    always_comb begin
        tgl_at[0] = dbl(sh_nxt.tga);
        tgl_at[1] = dbl(sh_nxt.tgb);
    end

    generate
        for (genvar t = 0; t < NTGL; t++) begin : g_tgl
            tft_hline_tgl u_tgl (
                .clk   (clk),
                .rst_n (rst_n),
                .pos_i (cnt_nxt),
                .at_i  (tgl_at[t]),
                .lvl_o (tgl_q[t])
            );
        end
    endgenerate

    // blanking rule on the line about to run
    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;
    pos_t need;

    always_comb begin
        need      = data_beg + (pos_t'(sh_nxt.dsp) << 3) + GUARD;
        top_d.err = (need >= line_len(sh_nxt.tot));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign line_o    = win_q[W_LN];
    assign stp_o     = win_q[W_SP];
    assign de_o      = win_q[W_DE];
    assign oe_o      = win_q[W_OE];
    assign gck_o     = win_q[W_GC];
    assign tga_o     = tgl_q[0];
    assign tgb_o     = tgl_q[1];
    assign cfg_err_o = top_q.err;

endmodule

// File: rtl/tft_hline_chk.sv
module tft_hline_chk
    import tft_hline_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    line_o,
    input logic    stp_o,
    input logic    de_o,
    input logic    oe_o,
    input logic    gck_o,
    input logic    tga_o,
    input logic    tgb_o,
    input logic    cfg_err_o,
    input pos_t    cnt_i,
    input logic    run_i,
    input hfield_t sh_i
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!line_o && !stp_o && !de_o && !oe_o && !gck_o
                                      && !tga_o && !tgb_o && !cfg_err_o)
                else $error("outputs active in reset");
        end
    end

    p_line_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_i == '0) |-> line_o);

    p_stp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stp_o |=> !stp_o);

    p_de_follows_stp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stp_o) && cnt_i != '0 && sh_i.dsp != '0) |-> de_o);

    p_oe_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (cnt_i == dbl(sh_i.oed)));

    p_gck_with_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_o) |-> gck_o);

    p_tga_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tga_o != $past(tga_o)) |-> (cnt_i == dbl(sh_i.tga)));

    p_tgb_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgb_o != $past(tgb_o)) |-> (cnt_i == dbl(sh_i.tgb)));

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> $stable(sh_i));

endmodule

bind tft_hline_gen tft_hline_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_o    (line_o),
    .stp_o     (stp_o),
    .de_o      (de_o),
    .oe_o      (oe_o),
    .gck_o     (gck_o),
    .tga_o     (tga_o),
    .tgb_o     (tgb_o),
    .cfg_err_o (cfg_err_o),
    .cnt_i     (cnt_q),
    .run_i     (run_q),
    .sh_i      (sh_q)
);

// File: tb/sim_tft_hline_gen.sv
`timescale 1ns/1ps
module sim_tft_hline_gen;

    localparam int NSRC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [6:0] f_tot, f_lpw, f_dsp;
    logic [1:0] f_sph;
    logic [7:0] f_spl, f_oed, f_oew, f_gcw, f_tga, f_tgb;
    logic line_o, stp_o, de_o, oe_o, gck_o, tga_o, tgb_o, cfg_err_o;

    tft_hline_gen #(.NUM_SRC_IC(NSRC)) u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_total_i (f_tot), .cfg_lpw_i (f_lpw),
        .cfg_spd_hi_i (f_sph), .cfg_spd_lo_i (f_spl),
        .cfg_disp_i (f_dsp), .cfg_oe_dly_i (f_oed), .cfg_oe_wid_i (f_oew),
        .cfg_gck_wid_i (f_gcw), .cfg_tga_i (f_tga), .cfg_tgb_i (f_tgb),
        .line_o (line_o), .stp_o (stp_o), .de_o (de_o), .oe_o (oe_o),
        .gck_o (gck_o), .tga_o (tga_o), .tgb_o (tgb_o), .cfg_err_o (cfg_err_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state built from the requirements
    int m_c, m_run, m_ta, m_tb;
    int s_tot, s_lpw, s_spd, s_dsp, s_oed, s_oew, s_gcw, s_tga, s_tgb;

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b count=%0d", tag, act, exp, m_c);
        end
    endtask

    task automatic set_f(input int tot, input int lpw, input int spd, input int dsp,
                         input int oed, input int oew, input int gcw,
                         input int ta, input int tb);
        f_tot = 7'(tot); f_lpw = 7'(lpw);
        f_sph = 2'(spd >> 8); f_spl = 8'(spd);
        f_dsp = 7'(dsp); f_oed = 8'(oed); f_oew = 8'(oew);
        f_gcw = 8'(gcw); f_tga = 8'(ta); f_tgb = 8'(tb);
    endtask

    task automatic step_model();
        if (!rst_n) begin
            m_run = 0; m_c = 0; m_ta = 0; m_tb = 0;
        end else begin
            if (m_run == 0) begin
                m_run = 1; m_c = 0;
            end else if (m_c == (s_tot + 1) * 8 - 1) m_c = 0;
            else m_c++;
            if (m_c == 0) begin
                s_tot = f_tot; s_lpw = f_lpw; s_spd = {f_sph, f_spl};
                s_dsp = f_dsp; s_oed = f_oed; s_oew = f_oew; s_gcw = f_gcw;
                s_tga = f_tga; s_tgb = f_tgb;
            end
            if (m_c == 2 * s_tga) m_ta ^= 1;
            if (m_c == 2 * s_tgb) m_tb ^= 1;
        end
    endtask

    task automatic check_out();
        int lpl, ob, ow, gw, need;
        if (m_run == 0) begin
            chk("R1 line", line_o, 1'b0); chk("R1 stp", stp_o, 1'b0);
            chk("R1 de", de_o, 1'b0);     chk("R1 oe", oe_o, 1'b0);
            chk("R1 gck", gck_o, 1'b0);   chk("R1 tga", tga_o, 1'b0);
            chk("R1 tgb", tgb_o, 1'b0);   chk("R1 err", cfg_err_o, 1'b0);
        end else begin
            lpl  = s_lpw + 1;
            ob   = 2 * s_oed;
            ow   = (s_oew == 0) ? lpl : 2 * s_oew;
            gw   = (s_gcw == 0) ? lpl : 2 * s_gcw;
            need = s_spd + 4 + s_dsp * 8 + NSRC * 3 + 3;
            chk("R2 line", line_o, m_c < lpl);
            chk("R3 stp", stp_o, m_c == s_spd + 3);
            chk("R4 de", de_o, (m_c >= s_spd + 4) && (m_c < s_spd + 4 + s_dsp * 8));
            chk("R5 oe", oe_o, (m_c >= ob) && (m_c < ob + ow));
            chk("R6 gck", gck_o, m_c < gw);
            chk("R7 tga", tga_o, m_ta[0]);
            chk("R7 tgb", tgb_o, m_tb[0]);
            chk("R8 err", cfg_err_o, need >= (s_tot + 1) * 8);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        step_model();
        @(negedge clk);
        check_out();
    endtask

    // cycles from one line_o rise to the next
    task automatic line_gap(output int n);
        logic p;
        n = 0;
        p = line_o;
        for (int i = 0; i < 3000; i++) begin
            tick();
            n++;
            if (line_o && !p) break;
            p = line_o;
        end
    endtask

    initial begin
        int seed, n;
        seed = $urandom(20240611);
        m_run = 0; m_c = 0; m_ta = 0; m_tb = 0;
        set_f(3, 2, 5, 2, 4, 3, 2, 6, 1);
        // R1: reset quiet
        for (int i = 0; i < 4; i++) tick();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 70; i++) tick();

        // R2: shortest line, tiny pulses
        set_f(0, 1, 0, 0, 1, 1, 1, 2, 3);
        for (int i = 0; i < 40; i++) tick();

        // R5 R6: zero widths fall back to line pulse width
        set_f(15, 5, 10, 4, 3, 0, 0, 9, 0);
        for (int i = 0; i < 300; i++) tick();

        // R8: exact boundary (error) then one inside (no error)
        set_f(15, 3, 23, 10, 2, 2, 2, 1, 2);
        for (int i = 0; i < 260; i++) tick();
        set_f(15, 3, 22, 10, 2, 2, 2, 1, 2);
        for (int i = 0; i < 260; i++) tick();

        // R7: toggle positions past the line end
        set_f(15, 3, 10, 4, 2, 2, 2, 200, 255);
        for (int i = 0; i < 400; i++) tick();

        // R9: mid-line change of line length
        set_f(7, 3, 4, 2, 1, 1, 1, 5, 6);
        line_gap(n);
        line_gap(n);
        for (int i = 0; i < 10; i++) tick();
        f_tot = 7'd3;
        line_gap(n);
        total++;
        if (n != 54) begin
            bad++;
            $display("FAIL R9 rest of line act=%0d exp=%0d", n, 54);
        end
        line_gap(n);
        total++;
        if (n != 32) begin
            bad++;
            $display("FAIL R9 next line act=%0d exp=%0d", n, 32);
        end

        // random fields, changed at arbitrary points in a line
        for (int k = 0; k < 40; k++) begin
            set_f($urandom_range(0, 47), $urandom_range(0, 40), $urandom_range(0, 300),
                  $urandom_range(0, 30), $urandom_range(0, 150), $urandom_range(0, 60),
                  $urandom_range(0, 60), $urandom_range(0, 255), $urandom_range(0, 255));
            for (int i = 0; i < int'($urandom_range(20, 700)); i++) tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule